// File: doc/BRIEF.md
# Vectored Interrupt Controller with Pin Edge Detection

This block gathers every interrupt request of a small 8-bit microcontroller and turns them into one vectored request to the CPU. The requests come from three kinds of input:

- eight analog-port pins, each with its own mask and its own edge polarity;
- 29 general-purpose pins in four ports (8, 8, 8 and 5 pins), each with a per-pin mask and one polarity per port;
- two timer tap levels, plus single-cycle strobes from the bus-reset detector, five endpoints, the hub and the serial two-wire unit.

Each of the twelve sources owns a pending flag, which sets on the source's event whether or not the source is enabled. A per-source enable and a global enable decide which pending flags reach the CPU. A fixed priority picks the pending, enabled source with the lowest vector address. The CPU sees `irq_req` and the program-memory vector. It takes the interrupt with `irq_ack`, which clears the winner's flag and the global enable, and it signals the end of the handler with `irq_reti`. Firmware reaches the enables, the pin masks and polarities, and a pending-vector register through a byte-wide register port.

Top module: `vint_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `irq_req` is 0, `irq_vec` is 0, and every register reads 0x00.
- R2: The source order is bus reset, timer tap 0, timer tap 1, endpoints 0 to 4, hub, analog port, general-purpose port, two-wire unit. Source i has vector 2*(i+1), so the vectors run from 0x0002 to 0x0018.
- R3: Among pending, enabled sources, the one with the lowest vector drives `irq_vec`.
- R4: An analog-port pin has a mask bit at 0x31 and a polarity bit at 0x32 (0 = rising, 1 = falling). A matching edge on an unmasked pin sets the analog-port flag on the third rising clock edge after the pin changes. A masked pin does nothing.
- R5: The masks for general-purpose ports 0 to 3 sit at 0x04 to 0x07 (bit n = pin n of that port). The polarity of port p is bit p at 0x08 (0 = rising, 1 = falling). Unmasked matching edges set the general-purpose flag with the same timing as R4.
- R6: A timer tap sets its flag only on a 0-to-1 change of its level. A level held high raises no further request.
- R7: A source whose enable is 0 still latches its pending flag but raises no request. When its enable is later set, the source requests. The enables are: 0x20 bits 0 to 6 for bus reset, tap 0, tap 1, hub, analog, general-purpose and two-wire; 0x21 bits 0 to 4 for endpoints 0 to 4.
- R8: `irq_req` is high only while the global enable (bit 7 of 0x20) is 1 and at least one pending source is enabled.
- R9: `irq_ack` while `irq_req` is high clears the winner's flag and the global enable. When `irq_req` is low, `irq_ack` has no effect.
- R10: `irq_reti` sets the global enable. If an accepted acknowledge arrives in the same cycle, the acknowledge wins. Both take priority over a register write to bit 7.
- R11: A read of 0x23 returns the low byte of the winning vector, ignoring the global enable, and clears that source's flag. With no enabled source pending it returns 0x00 and clears nothing.
- R12: A new event in the cycle that clears the same flag leaves the flag set.
- R13: A pin or tap held at a constant level after one transition produces exactly one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dac_pin | input | 8 | Analog-port pin levels (asynchronous) |
| gpio_pin | input | 29 | General-purpose pin levels, port 0 in bits 7:0 (asynchronous) |
| tmr_tap | input | 2 | Timer tap levels, bit 0 the short period |
| usb_rst_stb | input | 1 | Bus-reset event strobe |
| ep_stb | input | 5 | Endpoint event strobes |
| hub_stb | input | 1 | Hub event strobe |
| i2c_stb | input | 1 | Two-wire unit event strobe |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Read data, valid in the cycle `reg_rd` is high |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 14 | Vector address of the winning source |
| irq_ack | input | 1 | CPU acknowledge |
| irq_reti | input | 1 | Return-from-interrupt indication |

## Verification
A lost or stuck pending flag shows up directly: either `irq_req` stays high after the acknowledge, or the next read of 0x23 returns a vector that is wrong or 0x00. A reference model checks this on every clock. If the synchroniser depth is wrong, the pin event moves by one or more cycles; the model expects it exactly on the third edge, so the mismatch shows up within that many cycles. A global-enable flip-flop that fails to clear on acknowledge or to set on return shows as `irq_req` disagreeing with the model in the very next cycle.

// File: rtl/irqc_pkg.sv
// Package: shared constants for the vectored interrupt controller.
// Assumes a fixed twelve-source map; the vector is derived from the source index.
package irqc_pkg;

    localparam int NUM_SRC   = 12;
    localparam int SRC_IDX_W = $clog2(NUM_SRC);
    localparam int VEC_W     = 14;

    // Source indices, in priority order (lowest index wins).
    localparam int SRC_BUSRST = 0;
    localparam int SRC_TAP0   = 1;
    localparam int SRC_TAP1   = 2;
    localparam int SRC_EP0    = 3;
    localparam int NUM_EP     = 5;
    localparam int SRC_HUB    = 8;
    localparam int SRC_DAC    = 9;
    localparam int SRC_GPIO   = 10;
    localparam int SRC_I2C    = 11;

    // Register addresses.
    localparam logic [7:0] ADDR_GMASK0 = 8'h04;
    localparam logic [7:0] ADDR_GPOL   = 8'h08;
    localparam logic [7:0] ADDR_SYSEN  = 8'h20;
    localparam logic [7:0] ADDR_EPEN   = 8'h21;
    localparam logic [7:0] ADDR_VEC    = 8'h23;
    localparam logic [7:0] ADDR_DMASK  = 8'h31;
    localparam logic [7:0] ADDR_DPOL   = 8'h32;

    // Vector address of a source: two bytes per entry, table starting at 2.
    function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_IDX_W-1:0] idx);
        return (VEC_W'(idx) + VEC_W'(1)) << 1;
    endfunction

endpackage

// File: rtl/irqc_pin_edge.sv
// Module: irqc_pin_edge
// Synchronises a group of asynchronous pins through STAGES flops, keeps
// one more flop of history, and reports a masked edge of the chosen polarity.
// Assumes pins change no faster than the synchroniser can follow.
module irqc_pin_edge #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] pol,     // 0 rising, 1 falling
    input  logic [W-1:0] mask,    // 1 = pin may raise an event
    output logic         evt
);

    logic [STAGES:0][W-1:0] sh;
    logic [W-1:0]           cur;
    logic [W-1:0]           prv;
    logic [W-1:0]           hit;

    // Shift pins through synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], pin};
    end

    assign cur = sh[STAGES-1];
    assign prv = sh[STAGES];

    // Select the edge direction per pin and apply the pin mask.
    always_comb begin
        hit = ((cur & ~prv & ~pol) | (~cur & prv & pol)) & mask;
        evt = |hit;
    end

endmodule

// File: rtl/irqc_pend.sv
// Module: irqc_pend
// One pending flag per source; set has priority over clear in the same cycle.
// Assumes set and clear are single-cycle qualified pulses.
module irqc_pend #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    // Update each flag: clear first, then let a new event win.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | set;
    end

endmodule

// File: rtl/irqc_arb.sv
// Module: irqc_arb
// Fixed-priority arbiter: the lowest set bit of req wins.
// Assumes req is already qualified by the per-source enables.
module irqc_arb #(
    parameter int N  = 12,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  grant
);

    // Scan from the top down so the lowest index is the last one kept.
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        grant = '0;
        if (valid) grant[idx] = 1'b1;
    end

endmodule

// File: rtl/vint_ctrl.sv
// Module: vint_ctrl (top)
// Collects pin, timer and peripheral events into pending flags, arbitrates
// the enabled ones and presents a vectored request with acknowledge.
// Assumes strobes and taps are synchronous to clk; pins are asynchronous.
module vint_ctrl
    import irqc_pkg::*;
#(
    parameter int DAC_W       = 8,
    parameter int GPIO_PORTS  = 4,
    parameter int PORT_W      = 8,
    parameter int GPIO_LAST_W = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  dac_pin,
    input  logic [28:0] gpio_pin,
    input  logic [1:0]  tmr_tap,
    input  logic        usb_rst_stb,
    input  logic [4:0]  ep_stb,
    input  logic        hub_stb,
    input  logic        i2c_stb,
    input  logic [7:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    input  logic        reg_rd,
    output logic [7:0]  reg_rdata,
    output logic        irq_req,
    output logic [13:0] irq_vec,
    input  logic        irq_ack,
    input  logic        irq_reti
);

    localparam int GPIO_W = PORT_W * (GPIO_PORTS - 1) + GPIO_LAST_W;

    logic [6:0]          sys_en_q;
    logic                gie_q;
    logic [NUM_EP-1:0]   ep_en_q;
    logic [DAC_W-1:0]    dmask_q;
    logic [DAC_W-1:0]    dpol_q;
    logic [GPIO_PORTS-1:0] gpol_q;
    logic [GPIO_W-1:0]   gmask;
    logic [GPIO_W-1:0]   gpol_pin;
    logic [1:0]          tap_q;
    logic                dac_evt;
    logic                gpio_evt;
    logic [NUM_SRC-1:0]  src_set;
    logic [NUM_SRC-1:0]  src_clr;
    logic [NUM_SRC-1:0]  src_en;
    logic [NUM_SRC-1:0]  pend_q;
    logic [NUM_SRC-1:0]  grant;
    logic                win_valid;
    logic [SRC_IDX_W-1:0] win_idx;
    logic [VEC_W-1:0]    win_vec;
    logic                ack_take;
    logic                rd_take;

    // Write decode for register targets owned by the top.
    function automatic logic hit_wr(input logic [7:0] a);
        return reg_wr && (reg_addr == a);
    endfunction

    // Source enables (0x20 bits 6:0), endpoint enables and analog pin config.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_en_q <= '0;
            ep_en_q  <= '0;
            dmask_q  <= '0;
            dpol_q   <= '0;
            gpol_q   <= '0;
        end else begin
            if (hit_wr(ADDR_SYSEN)) sys_en_q <= reg_wdata[6:0];
            if (hit_wr(ADDR_EPEN))  ep_en_q  <= reg_wdata[NUM_EP-1:0];
            if (hit_wr(ADDR_DMASK)) dmask_q  <= reg_wdata[DAC_W-1:0];
            if (hit_wr(ADDR_DPOL))  dpol_q   <= reg_wdata[DAC_W-1:0];
            if (hit_wr(ADDR_GPOL))  gpol_q   <= reg_wdata[GPIO_PORTS-1:0];
        end
    end

    // Global enable: acknowledge beats return, return beats a register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  gie_q <= 1'b0;
        else if (ack_take)           gie_q <= 1'b0;
        else if (irq_reti)           gie_q <= 1'b1;
        else if (hit_wr(ADDR_SYSEN)) gie_q <= reg_wdata[7];
    end

    // Per-port pin masks and fanned-out per-pin polarity.
    for (genvar p = 0; p < GPIO_PORTS; p++) begin : g_port
        localparam int PW = (p == GPIO_PORTS - 1) ? GPIO_LAST_W : PORT_W;
        logic [PW-1:0] pmask_q;

        // Capture this port's mask when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                              pmask_q <= '0;
            else if (hit_wr(ADDR_GMASK0 + 8'(p)))    pmask_q <= reg_wdata[PW-1:0];
        end

        assign gmask[p*PORT_W +: PW]    = pmask_q;
        assign gpol_pin[p*PORT_W +: PW] = {PW{gpol_q[p]}};
    end

    irqc_pin_edge #(.W(DAC_W), .STAGES(SYNC_STAGES)) u_dac_edge (
        .clk (clk), .rst_n (rst_n), .pin (dac_pin[DAC_W-1:0]),
        .pol (dpol_q), .mask (dmask_q), .evt (dac_evt)
    );

    irqc_pin_edge #(.W(GPIO_W), .STAGES(SYNC_STAGES)) u_gpio_edge (
        .clk (clk), .rst_n (rst_n), .pin (gpio_pin[GPIO_W-1:0]),
        .pol (gpol_pin), .mask (gmask), .evt (gpio_evt)
    );

    // Timer tap history for 0-to-1 detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= '0;
        else        tap_q <= tmr_tap;
    end

    // Map events and enables onto the source order.
    always_comb begin
        src_set = '0;
        src_set[SRC_BUSRST]                = usb_rst_stb;
        src_set[SRC_TAP0]                  = tmr_tap[0] & ~tap_q[0];
        src_set[SRC_TAP1]                  = tmr_tap[1] & ~tap_q[1];
        src_set[SRC_EP0 +: NUM_EP]         = ep_stb;
        src_set[SRC_HUB]                   = hub_stb;
        src_set[SRC_DAC]                   = dac_evt;
        src_set[SRC_GPIO]                  = gpio_evt;
        src_set[SRC_I2C]                   = i2c_stb;

        src_en = '0;
        src_en[SRC_BUSRST]                 = sys_en_q[0];
        src_en[SRC_TAP0]                   = sys_en_q[1];
        src_en[SRC_TAP1]                   = sys_en_q[2];
        src_en[SRC_EP0 +: NUM_EP]          = ep_en_q;
        src_en[SRC_HUB]                    = sys_en_q[3];
        src_en[SRC_DAC]                    = sys_en_q[4];
        src_en[SRC_GPIO]                   = sys_en_q[5];
        src_en[SRC_I2C]                    = sys_en_q[6];
    end

    irqc_arb #(.N(NUM_SRC), .IW(SRC_IDX_W)) u_arb (
        .req (pend_q & src_en), .valid (win_valid), .idx (win_idx), .grant (grant)
    );

    // Clear the winner on an accepted acknowledge or a pending-vector read.
    always_comb begin
        win_vec  = win_valid ? vec_of(win_idx) : '0;
        ack_take = irq_ack && irq_req;
        rd_take  = reg_rd && (reg_addr == ADDR_VEC);
        src_clr  = grant & {NUM_SRC{ack_take | rd_take}};
    end

    irqc_pend #(.N(NUM_SRC)) u_pend (
        .clk (clk), .rst_n (rst_n), .set (src_set), .clr (src_clr), .pend (pend_q)
    );

    assign irq_req = gie_q && win_valid;
    assign irq_vec = win_vec;

    // Read mux; write-only registers read as zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                ADDR_SYSEN: reg_rdata = {gie_q, sys_en_q};
                ADDR_EPEN:  reg_rdata = 8'(ep_en_q);
                ADDR_VEC:   reg_rdata = win_vec[7:0];
                default:    reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqc_checker.sv
// Module: irqc_checker
// Concurrent properties of the interrupt controller, bound into vint_ctrl.
module irqc_checker #(
    parameter int N = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         irq_req,
    input logic [13:0]  irq_vec,
    input logic         irq_ack,
    input logic         irq_reti,
    input logic         gie,
    input logic [N-1:0] pend,
    input logic [N-1:0] src_en,
    input logic [N-1:0] grant,
    input logic [4:0]   ep_stb
);

    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_vec_in_table_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[0] == 1'b0 && irq_vec >= 14'd2 && irq_vec <= 14'd24));

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & src_en) == '0) |-> !irq_req);

    assert_no_req_without_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq_req);

    assert_ack_drops_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> !gie);

    assert_reti_raises_gie_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_reti && !(irq_ack && irq_req)) |=> gie);

    assert_set_beats_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ep_stb[0] |=> pend[3]);

endmodule

bind vint_ctrl irqc_checker #(.N(irqc_pkg::NUM_SRC)) u_irqc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec),
    .irq_ack  (irq_ack),
    .irq_reti (irq_reti),
    .gie      (gie_q),
    .pend     (pend_q),
    .src_en   (src_en),
    .grant    (grant),
    .ep_stb   (ep_stb)
);

// File: tb/test_vint_ctrl.sv
module test_vint_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dac_pin = '0;
    logic [28:0] gpio_pin = '0;
    logic [1:0]  tmr_tap = '0;
    logic        usb_rst_stb = 1'b0;
    logic [4:0]  ep_stb = '0;
    logic        hub_stb = 1'b0;
    logic        i2c_stb = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic        irq_req;
    logic [13:0] irq_vec;
    logic        irq_ack = 1'b0;
    logic        irq_reti = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vint_ctrl i_vint_ctrl (
        .clk (clk), .rst_n (rst_n), .dac_pin (dac_pin), .gpio_pin (gpio_pin),
        .tmr_tap (tmr_tap), .usb_rst_stb (usb_rst_stb), .ep_stb (ep_stb),
        .hub_stb (hub_stb), .i2c_stb (i2c_stb), .reg_addr (reg_addr),
        .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rd (reg_rd),
        .reg_rdata (reg_rdata), .irq_req (irq_req), .irq_vec (irq_vec),
        .irq_ack (irq_ack), .irq_reti (irq_reti)
    );

    // ---------------- reference model ----------------
    bit [11:0] m_pend;
    bit [6:0]  m_sys;
    bit        m_gie;
    bit [4:0]  m_ep;
    bit [7:0]  m_dmask, m_dpol, m_d1, m_d2, m_dp;
    bit [28:0] m_gmask, m_g1, m_g2, m_gp;
    bit [3:0]  m_gpol;
    bit [1:0]  m_tp;

    function automatic bit m_en(int i);
        case (i)
            0: return m_sys[0];
            1: return m_sys[1];
            2: return m_sys[2];
            8: return m_sys[3];
            9: return m_sys[4];
            10: return m_sys[5];
            11: return m_sys[6];
            default: return m_ep[i-3];
        endcase
    endfunction

    function automatic int m_win();
        for (int i = 0; i < 12; i++)
            if (m_pend[i] && m_en(i)) return i;
        return -1;
    endfunction

    function automatic bit m_req();
        return m_gie && (m_win() >= 0);
    endfunction

    function automatic int m_vec();
        int w;
        w = m_win();
        return (w < 0) ? 0 : 2 * (w + 1);
    endfunction

    function automatic int m_rd();
        if (!reg_rd) return 0;
        if (reg_addr == 8'h20) return {m_gie, m_sys};
        if (reg_addr == 8'h21) return m_ep;
        if (reg_addr == 8'h23) return m_vec() & 8'hFF;
        return 0;
    endfunction

    always @(posedge clk) begin
        bit dev, gev, ack, rclr;
        int w;
        if (!rst_n) begin
            m_pend = 0; m_sys = 0; m_gie = 0; m_ep = 0;
            m_dmask = 0; m_dpol = 0; m_d1 = 0; m_d2 = 0; m_dp = 0;
            m_gmask = 0; m_g1 = 0; m_g2 = 0; m_gp = 0; m_gpol = 0; m_tp = 0;
        end else begin
            dev = 0;
            for (int j = 0; j < 8; j++)
                if (m_dmask[j] && (m_dpol[j] ? (!m_d2[j] && m_dp[j]) : (m_d2[j] && !m_dp[j])))
                    dev = 1;
            gev = 0;
            for (int j = 0; j < 29; j++)
                if (m_gmask[j] && (m_gpol[j/8] ? (!m_g2[j] && m_gp[j]) : (m_g2[j] && !m_gp[j])))
                    gev = 1;
            w = m_win();
            ack = irq_ack && m_req();
            rclr = reg_rd && reg_addr == 8'h23;
            if ((ack || rclr) && w >= 0) m_pend[w] = 0;
            if (usb_rst_stb) m_pend[0] = 1;
            if (tmr_tap[0] && !m_tp[0]) m_pend[1] = 1;
            if (tmr_tap[1] && !m_tp[1]) m_pend[2] = 1;
            for (int e = 0; e < 5; e++) if (ep_stb[e]) m_pend[3+e] = 1;
            if (hub_stb) m_pend[8] = 1;
            if (dev) m_pend[9] = 1;
            if (gev) m_pend[10] = 1;
            if (i2c_stb) m_pend[11] = 1;
            if (ack) m_gie = 0;
            else if (irq_reti) m_gie = 1;
            else if (reg_wr && reg_addr == 8'h20) m_gie = reg_wdata[7];
            if (reg_wr) begin
                case (reg_addr)
                    8'h20: m_sys = reg_wdata[6:0];
                    8'h21: m_ep = reg_wdata[4:0];
                    8'h31: m_dmask = reg_wdata;
                    8'h32: m_dpol = reg_wdata;
                    8'h08: m_gpol = reg_wdata[3:0];
                    8'h04: m_gmask[7:0] = reg_wdata;
                    8'h05: m_gmask[15:8] = reg_wdata;
                    8'h06: m_gmask[23:16] = reg_wdata;
                    8'h07: m_gmask[28:24] = reg_wdata[4:0];
                    default: ;
                endcase
            end
            m_dp = m_d2; m_d2 = m_d1; m_d1 = dac_pin;
            m_gp = m_g2; m_g2 = m_g1; m_g1 = gpio_pin;
            m_tp = tmr_tap;
        end
    end

    // Every-clock comparison, 2 ns after the falling edge.
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            n_chk++;
            if (irq_req !== m_req()) begin
                n_bad++;
                $display("FAIL R8 cycle %0d irq_req act=%0b exp=%0b", cyc, irq_req, m_req());
            end
            n_chk++;
            if (irq_vec !== 14'(m_vec())) begin
                n_bad++;
                $display("FAIL R3 cycle %0d irq_vec act=%0h exp=%0h", cyc, irq_vec, m_vec());
            end
            n_chk++;
            if (reg_rdata !== 8'(m_rd())) begin
                n_bad++;
                $display("FAIL R11 cycle %0d reg_rdata act=%0h exp=%0h", cyc, reg_rdata, m_rd());
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
        reg_addr = a; reg_rd = 1'b1;
        #2 chk(reg_rdata == 8'(exp), tag, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic irq_chk(input bit req, input int vec, input string tag);
        #2;
        chk(irq_req == req, tag, irq_req, req);
        if (req) chk(irq_vec == 14'(vec), tag, irq_vec, vec);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        irq_chk(0, 0, "R1 irq_req after reset");
        rd_chk(8'h20, 0, "R1 sys enables");
        rd_chk(8'h21, 0, "R1 endpoint enables");
        rd_chk(8'h23, 0, "R1 pending vector");

        // R7: disabled source latches, enabled later requests
        ep_stb = 5'b00001; @(negedge clk); ep_stb = '0;
        rd_chk(8'h23, 0, "R7 disabled source hidden");
        wr(8'h21, 8'h1F);
        rd_chk(8'h23, 8'h08, "R7 latched after enable");
        rd_chk(8'h23, 0, "R11 flag cleared by read");
        wr(8'h20, 8'h7F);

        // R2/R11: endpoint 2 vector via register read
        ep_stb = 5'b00100; @(negedge clk); ep_stb = '0;
        irq_chk(0, 0, "R8 no request while global off");
        rd_chk(8'h23, 8'h0C, "R2 endpoint 2 vector");

        // R12: event and clear of the same source in one cycle
        ep_stb = 5'b00001; @(negedge clk);
        reg_addr = 8'h23; reg_rd = 1'b1;
        #2 chk(reg_rdata == 8'h08, "R12 read during re-set", reg_rdata, 8'h08);
        @(negedge clk); reg_rd = 1'b0; ep_stb = '0;
        rd_chk(8'h23, 8'h08, "R12 flag survives");

        // R3/R9/R10: priority and handshake
        usb_rst_stb = 1; hub_stb = 1; i2c_stb = 1; @(negedge clk);
        usb_rst_stb = 0; hub_stb = 0; i2c_stb = 0;
        wr(8'h20, 8'hFF);
        irq_chk(1, 16'h0002, "R3 bus reset wins");
        irq_ack = 1; @(negedge clk); irq_ack = 0;
        irq_chk(0, 0, "R9 ack clears global enable");
        rd_chk(8'h20, 8'h7F, "R9 global bit cleared");
        irq_reti = 1; @(negedge clk); irq_reti = 0;
        irq_chk(1, 16'h0012, "R10 return re-enables, hub next");
        irq_ack = 1; irq_reti = 1; @(negedge clk); irq_ack = 0; irq_reti = 0;
        irq_chk(0, 0, "R10 ack beats return");
        irq_reti = 1; @(negedge clk); irq_reti = 0;
        irq_chk(1, 16'h0018, "R2 two-wire vector");
        irq_ack = 1; @(negedge clk); irq_ack = 0;
        irq_reti = 1; @(negedge clk); irq_reti = 0;
        irq_chk(0, 0, "R9 all served");
        irq_ack = 1; @(negedge clk); irq_ack = 0;
        rd_chk(8'h20, 8'hFF, "R9 idle ack ignored");
        wr(8'h20, 8'h7F);

        // R6/R13: timer tap edge only
        tmr_tap[0] = 1; idle(4);
        rd_chk(8'h23, 8'h04, "R6 tap 0 rise");
        idle(3);
        rd_chk(8'h23, 0, "R13 held tap no repeat");
        tmr_tap[0] = 0; idle(2);
        rd_chk(8'h23, 0, "R6 tap fall ignored");
        tmr_tap[1] = 1; idle(2); tmr_tap[1] = 0;
        rd_chk(8'h23, 8'h06, "R6 tap 1 rise");

        // R4: analog pins
        wr(8'h31, 8'h05); wr(8'h32, 8'h04);
        dac_pin[1] = 1; idle(4);
        rd_chk(8'h23, 0, "R4 masked pin");
        dac_pin[0] = 1; idle(2);
        rd_chk(8'h23, 0, "R4 not before third edge");
        idle(1);
        rd_chk(8'h23, 8'h14, "R4 rising pin 0");
        dac_pin[2] = 1; idle(4);
        rd_chk(8'h23, 0, "R4 rise on falling pin");
        dac_pin[2] = 0; idle(4);
        rd_chk(8'h23, 8'h14, "R4 falling pin 2");
        idle(3);
        rd_chk(8'h23, 0, "R13 single analog event");

        // R5: general-purpose pins
        wr(8'h04, 8'h01); wr(8'h07, 8'h10); wr(8'h08, 8'h08);
        gpio_pin[28] = 1; idle(4);
        rd_chk(8'h23, 0, "R5 falling port ignores rise");
        gpio_pin[28] = 0; idle(4);
        rd_chk(8'h23, 8'h16, "R5 port 3 falling");
        gpio_pin[8] = 1; idle(4);
        rd_chk(8'h23, 0, "R5 masked port 1 pin");
        gpio_pin[0] = 1; idle(4);
        rd_chk(8'h23, 8'h16, "R5 port 0 rising");

        idle(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule